// File: doc/BRIEF.md
# Multi-Match OS Timer Core

This block is a free-running 32-bit up-counter with four programmable match channels. Each cycle in which the count-enable tick is high, the counter advances by one. A channel whose match value equals the counter's new value, and whose enable bit is set, latches a pending flag. That flag drives the channel's own level interrupt line.

Software reaches the block through a simple single-cycle register bus. Through it, software can load the counter, program the match values and set the enable mask. It also acknowledges events by writing ones to the pending register. The bus decodes a 4 KB window. Word offsets outside the defined registers, and unaligned addresses, raise a bus error and change nothing. The enable register is 12 bits wide, so the upper bits can serve channels that an extension unit adds. A watchdog-enable word is kept as plain storage.

Top module: `os_timer_core`

## Requirements
- R1: After reset every register reads zero and all `irq_o` bits are low.
- R2: On a clock edge with `tick_i` high the counter advances by one, wrapping from 0xFFFFFFFF to 0. With `tick_i` low it holds.
- R3: A write to the counter (offset 0x18) loads the written value at that edge and takes priority over a tick in the same cycle. Counting resumes from the loaded value, and reads of 0x18 return the live count.
- R4: Match values sit at offsets 0x00, 0x04, 0x08 and 0x0C for channels 0 to 3, and each holds all 32 written bits.
- R5: Channel i matches when a tick edge makes the counter equal to its match value. With enable bit i set, pending bit i and `irq_o[i]` go high from that edge. Loading the counter with the match value is not a match.
- R6: A match on a channel whose enable bit is clear leaves its pending bit and interrupt unchanged. Clearing an enable bit does not clear a bit that is already pending.
- R7: The enable register (offset 0x10) stores bits [11:0] of the written value and reads zero above them. Bit i for i < 4 enables channel i, and bits 4 to 11 have no effect on this block.
- R8: The pending register (offset 0x14) reads the pending bits in [3:0]. Writing ones clears those bits, and only channels that were pending drop their interrupt. Zeros have no effect, and an interrupt stays high until cleared.
- R9: When a write clears a pending bit in the same cycle as a new match on that channel, the bit stays set.
- R10: The watchdog-enable register (offset 0x1C) stores and returns all 32 bits and affects nothing else.
- R11: `err_o` is high, in the same cycle as `req_i`, for any unaligned address or any offset above 0x1C. Such an access changes no state and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable for this cycle |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read |
| err_o | output | 1 | Bus error for the current access |
| irq_o | output | 4 | Level interrupt per channel |

## Verification
The hazardous overlap is a pending-register clear landing on the same edge as a new match for that channel. A similar overlap is a counter load coinciding with a tick. The bench provokes the first by letting channel 0 match, reloading the counter one below the match value, and then issuing the clear together with a tick. The behavioural model applies set-over-clear and load-over-tick, and the interrupt lines and read-back values are compared with it on every clock.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
  typedef enum logic [2:0] {
    RK_NONE,
    RK_MATCH,
    RK_IEN,
    RK_STAT,
    RK_CNT,
    RK_WDOG
  } reg_kind_e;
endpackage

// File: rtl/ostmr_counter.sv
module ostmr_counter #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] inc_o
);
  logic [CW-1:0] cnt_q;

  assign inc_o = cnt_q + CW'(1);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= inc_o;
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> cnt_q == $past(cnt_q) + CW'(1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q)); // R2
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i)); // R3
endmodule

// File: rtl/ostmr_match.sv
module ostmr_match #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] inc_i,
  output logic [CW-1:0] val_o,
  output logic          hit_o
);
  logic [CW-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   val_q <= '0;
    else if (wr_i) val_q <= wdata_i;
  end

  assign val_o = val_q;
  // compare against the value the counter is about to take
  assign hit_o = tick_i && !load_i && (inc_i == val_q);
endmodule

// File: rtl/ostmr_status.sv
module ostmr_status #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] hit_i,
  input  logic [NCH-1:0] en_i,
  input  logic           clr_wr_i,
  input  logic [NCH-1:0] clr_mask_i,
  output logic [NCH-1:0] st_o
);
  logic [NCH-1:0] st_q, set_v, clr_v;

  assign set_v = hit_i & en_i;
  assign clr_v = clr_wr_i ? (clr_mask_i & st_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (st_q & ~clr_v) | set_v;  // set wins
  end

  assign st_o = st_q;

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_SET_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!st_q[i] && !(hit_i[i] && en_i[i])) |=> !st_q[i]); // R6
    AST_SET_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_i[i] && en_i[i]) |=> st_q[i]); // R9
    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[i] && !(clr_wr_i && clr_mask_i[i])) |=> st_q[i]); // R8
    AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_wr_i && clr_mask_i[i] && !hit_i[i]) |=> !st_q[i]); // R8
  end
endmodule

// File: rtl/os_timer_core.sv
module os_timer_core #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 12,
  parameter int unsigned IEW = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic           err_o,
  output logic [NCH-1:0] irq_o
);
  import ostmr_pkg::*;

  localparam int unsigned WIW = AW - 2;
  localparam int unsigned MIW = $clog2(NCH);
  localparam logic [WIW-1:0] W_IEN  = WIW'(NCH);
  localparam logic [WIW-1:0] W_STAT = WIW'(NCH + 1);
  localparam logic [WIW-1:0] W_CNT  = WIW'(NCH + 2);
  localparam logic [WIW-1:0] W_WDOG = WIW'(NCH + 3);

  reg_kind_e      kind;
  logic [WIW-1:0] widx;
  logic           wr, cnt_ld;
  logic [DW-1:0]  cnt, inc, rd_val;
  logic [DW-1:0]  mt_val [NCH];
  logic [NCH-1:0] hit, st;
  logic [IEW-1:0] ien_q;
  logic [DW-1:0]  wd_q;

  assign widx = addr_i[AW-1:2];

  always_comb begin
    if (addr_i[1:0] != 2'b00) kind = RK_NONE;
    else if (widx < W_IEN)    kind = RK_MATCH;
    else if (widx == W_IEN)   kind = RK_IEN;
    else if (widx == W_STAT)  kind = RK_STAT;
    else if (widx == W_CNT)   kind = RK_CNT;
    else if (widx == W_WDOG)  kind = RK_WDOG;
    else                      kind = RK_NONE;
  end

  assign err_o  = req_i && (kind == RK_NONE);
  assign wr     = req_i && we_i && (kind != RK_NONE);
  assign cnt_ld = wr && (kind == RK_CNT);

  ostmr_counter #(.CW(DW)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .load_i(cnt_ld), .load_val_i(wdata_i),
    .cnt_o(cnt), .inc_o(inc)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ostmr_match #(.CW(DW)) u_mt (
      .clk_i, .rst_ni,
      .wr_i(wr && (kind == RK_MATCH) && (widx[MIW-1:0] == MIW'(i))),
      .wdata_i, .tick_i, .load_i(cnt_ld), .inc_i(inc),
      .val_o(mt_val[i]), .hit_o(hit[i])
    );
  end

  ostmr_status #(.NCH(NCH)) u_st (
    .clk_i, .rst_ni,
    .hit_i(hit), .en_i(ien_q[NCH-1:0]),
    .clr_wr_i(wr && (kind == RK_STAT)), .clr_mask_i(wdata_i[NCH-1:0]),
    .st_o(st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      wd_q  <= '0;
    end else if (wr) begin
      if (kind == RK_IEN)  ien_q <= wdata_i[IEW-1:0];
      if (kind == RK_WDOG) wd_q  <= wdata_i;
    end
  end

  always_comb begin
    unique case (kind)
      RK_MATCH: rd_val = mt_val[widx[MIW-1:0]];
      RK_IEN:   rd_val = {{(DW-IEW){1'b0}}, ien_q};
      RK_STAT:  rd_val = {{(DW-NCH){1'b0}}, st};
      RK_CNT:   rd_val = cnt;
      RK_WDOG:  rd_val = wd_q;
      default:  rd_val = '0;
    endcase
  end

  assign rdata_o = (req_i && !we_i) ? rd_val : '0;
  assign irq_o   = st;

  AST_ERR_NOWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && err_o) |=> ($stable(wd_q) && $stable(ien_q))); // R11
  AST_ERR_RDZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == '0); // R11
endmodule

// File: tb/sim_os_timer_core.sv
`timescale 1ns/1ps
module sim_os_timer_core;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        tick_i = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        err_o;
  logic [3:0]  irq_o;

  always #4 clk_i = ~clk_i;

  os_timer_core u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_cnt = '0, m_wd = '0;
  logic [31:0] m_mt [4] = '{default: '0};
  logic [11:0] m_ien = '0;
  logic [3:0]  m_st = '0;
  logic        tk = 1'b0;

  localparam logic [11:0] A_IEN = 12'h010, A_ST = 12'h014, A_CNT = 12'h018, A_WD = 12'h01C;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_bad(input logic [11:0] a);
    return (a[1:0] != 2'b00) || (a > 12'h01C);
  endfunction

  function automatic logic [31:0] m_rd(input logic [11:0] a);
    if (m_bad(a)) return '0;
    if (a < A_IEN) return m_mt[a[3:2]];
    case (a)
      A_IEN:   return {20'h0, m_ien};
      A_ST:    return {28'h0, m_st};
      A_CNT:   return m_cnt;
      default: return m_wd;
    endcase
  endfunction

  task automatic cyc(input logic rq, input logic we, input logic [11:0] a,
                     input logic [31:0] d, input string tag);
    logic [3:0] hit, clr;
    bit wr, ld;
    @(negedge clk_i);
    req_i = rq; we_i = we; addr_i = a; wdata_i = d; tick_i = tk;
    #2;
    chk(err_o == (rq && m_bad(a)), "R11 err", {31'h0, err_o}, {31'h0, rq && m_bad(a)});
    if (rq && !we) chk(rdata_o == m_rd(a), tag, rdata_o, m_rd(a));
    @(posedge clk_i);
    wr = rq && we && !m_bad(a);
    ld = wr && (a == A_CNT);
    for (int i = 0; i < 4; i++)
      hit[i] = tk && !ld && ((m_cnt + 32'd1) == m_mt[i]) && m_ien[i];
    clr = (wr && a == A_ST) ? (d[3:0] & m_st) : 4'h0;
    m_st = (m_st & ~clr) | hit;
    if (ld) m_cnt = d;
    else if (tk) m_cnt = m_cnt + 32'd1;
    if (wr) begin
      if (a < A_IEN) m_mt[a[3:2]] = d;
      else if (a == A_IEN) m_ien = d[11:0];
      else if (a == A_WD) m_wd = d;
    end
    #1;
    req_i = 1'b0; we_i = 1'b0;
    chk(irq_o == m_st, {tag, " irq R5 R8"}, {28'h0, irq_o}, {28'h0, m_st});
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, tag);
  endtask
  task automatic rd(input logic [11:0] a, input string tag);
    cyc(1'b1, 1'b0, a, '0, tag);
  endtask
  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, '0, '0, tag);
  endtask
  task automatic rd_all(input string tag);
    for (int k = 0; k < 8; k++) rd(12'(k * 4), tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(irq_o == 4'h0, "R1 irq in reset", {28'h0, irq_o}, 32'h0);
    rst_ni = 1'b1;
    rd_all("R1 reset value");

    wr(12'h000, 32'd5, "R4"); wr(12'h004, 32'd8, "R4");
    wr(12'h008, 32'd6, "R4"); wr(12'h00C, 32'hDEADBEEF, "R4");
    for (int k = 0; k < 4; k++) rd(12'(k * 4), "R4 match readback");

    wr(A_IEN, 32'hABCDE5A3, "R7");
    rd(A_IEN, "R7 enable keeps 12 bits");

    // count with gaps; ch0 hits at 5, ch1 at 8, ch2 (disabled) at 6
    tk = 1'b1;
    for (int k = 0; k < 4; k++) rd(A_CNT, "R2 count");
    tk = 1'b0; idle(3, "R2 hold"); rd(A_CNT, "R2 hold");
    tk = 1'b1;
    for (int k = 0; k < 6; k++) rd(A_CNT, "R2 R5 R6 count");
    tk = 1'b0;
    rd(A_ST, "R5 R6 pending");

    wr(A_ST, 32'h0000000C, "R8 clear non-pending"); rd(A_ST, "R8");
    wr(A_ST, 32'h00000001, "R8 clear ch0"); rd(A_ST, "R8");
    wr(A_ST, 32'hFFFFFFFF, "R8 clear all"); rd(A_ST, "R8");

    // load priority over tick, and load to match value is not a match
    tk = 1'b1; wr(A_CNT, 32'h100, "R3 load vs tick"); tk = 1'b0;
    rd(A_CNT, "R3 loaded");
    wr(A_CNT, 32'd8, "R5 load equal"); rd(A_ST, "R5 load no match");
    tk = 1'b1; idle(2, "R3 continue"); tk = 1'b0; rd(A_CNT, "R3 continue");

    // wrap and match at zero
    wr(12'h00C, 32'h0, "R4"); wr(A_IEN, 32'h00F, "R7");
    wr(A_CNT, 32'hFFFFFFFE, "R2");
    tk = 1'b1; rd(A_CNT, "R2"); rd(A_CNT, "R2 wrap"); tk = 1'b0;
    rd(A_CNT, "R2 wrapped"); rd(A_ST, "R5 ch3 at wrap");
    wr(A_ST, 32'hF, "R8");

    // same-cycle set and clear
    wr(12'h000, 32'h20, "R4"); wr(A_CNT, 32'h1F, "R9");
    tk = 1'b1; idle(1, "R9 first hit"); tk = 1'b0;
    wr(A_CNT, 32'h1F, "R9 rewind");
    tk = 1'b1; wr(A_ST, 32'h1, "R9 clear with hit"); tk = 1'b0;
    rd(A_ST, "R9 set wins");
    wr(A_ST, 32'h1, "R9 plain clear"); rd(A_ST, "R9 cleared");

    // disabled channel with pending bit
    wr(A_CNT, 32'h1F, "R6"); tk = 1'b1; idle(1, "R6"); tk = 1'b0;
    wr(A_IEN, 32'hFFE, "R6 disable ch0"); rd(A_ST, "R6 stays pending");
    wr(A_ST, 32'h1, "R6"); wr(A_CNT, 32'h1F, "R6");
    tk = 1'b1; idle(1, "R6 disabled hit"); tk = 1'b0; rd(A_ST, "R6 no set");

    wr(A_WD, 32'h13579BDF, "R10"); rd(A_WD, "R10 storage"); rd(A_ST, "R10 no effect");

    // bad accesses
    wr(12'h020, 32'hFFFFFFFF, "R11"); wr(12'h016, 32'hFFFFFFFF, "R11");
    wr(12'hFFC, 32'hFFFFFFFF, "R11"); wr(12'h01D, 32'h0, "R11");
    rd(12'h040, "R11 read zero"); rd(12'h002, "R11 read zero");
    rd_all("R11 state unchanged");
    idle(2, "end");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule